// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block combines every reset request of a processor core into one active-high core reset. The requests are a supply power-up indication, a supply droop (brown-out) indication, a watchdog overflow pulse, a debugger-issued reset and the level of the external reset pin. The pin level is already synchronised and is active low. A set/reset style hold flag asserts the core reset as soon as any request is present. A startup counter runs on the slow watchdog RC clock and removes the reset once a timeout has elapsed.

The counter only advances on edges where no request is present. A low pin therefore keeps the core in reset for as long as it stays low. The timeout depends on the most recent cause. Supply-related causes use a fixed long count. Watchdog, pin and debugger causes use a count chosen by a 3-bit fuse field. The block also drives the constant reset-vector word address that the program counter loads. It keeps a cause code that can be read after release.

Top module: `reset_release_seq`

## Requirements
- R1: While `rst_n` is sampled low at a clock edge, `core_rst_o` is 1 and `cause_o` is the power-up code (1) after that edge.
- R2: A request present at a clock edge sets `core_rst_o` to 1 after that edge. The requests are `por_i`, `bor_i`, `wdt_ovf_i` or `dbg_rst_i` at 1, or `pin_level_i` at 0.
- R3: While `pin_level_i` stays 0, `core_rst_o` stays 1 however long the pin is held, including holds longer than every timeout.
- R4: After a power-up or brown-out cause, `core_rst_o` falls at the 1025th consecutive request-free clock edge, and not earlier.
- R5: After a watchdog, pin or debugger cause, `core_rst_o` falls at the Nth consecutive request-free edge, with N = 4 << `fuse_dly_i`. Code 0 gives 4, code 2 gives 16, code 3 gives 32 and code 7 gives 512.
- R6: A request that arrives while the timeout is running restarts the count from zero. The new count uses the timeout of the new cause.
- R7: `cause_o` codes are 1 power-up, 2 brown-out, 3 watchdog, 4 pin and 5 debugger. When requests coincide, the priority is power-up > brown-out > watchdog > pin > debugger. The code holds its value, including after release, until the next request.
- R8: `rst_vec_o` always equals 16'hFFF0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_slow_i | input | 1 | Slow watchdog RC clock that drives the startup counter |
| rst_n | input | 1 | Synchronous active-low initial-state reset |
| por_i | input | 1 | Power-up detector request, active high |
| bor_i | input | 1 | Brown-out detector request, active high |
| wdt_ovf_i | input | 1 | Watchdog overflow request, active high |
| pin_level_i | input | 1 | Synchronised external reset pin level, low requests reset |
| dbg_rst_i | input | 1 | Debugger target reset request, active high |
| fuse_dly_i | input | 3 | Fuse code that selects the non-supply timeout |
| core_rst_o | output | 1 | Active-high core reset |
| rst_vec_o | output | 16 | Reset-vector word address |
| cause_o | output | 3 | Code of the most recent reset cause |

## Verification
If the hold flag or the counter is wrong, the fault appears on `core_rst_o`. The release edge moves away from the exact request-free edge count, or the reset never falls at all. A wrong count therefore shows up at the first release after the fault, which is at most 1025 slow-clock edges after the last request. A cause register that loads the wrong code selects the wrong timeout, so the release edge shifts by hundreds of cycles. The wrong code is also visible on `cause_o` from the edge after the request. The restart check injects a second request partway through a short timeout. It catches a counter that fails to clear on that request.

// File: rtl/rst_seq_pkg.sv
// Shared types and helpers for the reset sequencer.
// Assumes: cause codes are fixed and read by software, so values are explicit.
package rst_seq_pkg;

    typedef enum logic [2:0] {
        CAUSE_NONE = 3'd0,
        CAUSE_POR  = 3'd1,
        CAUSE_BOR  = 3'd2,
        CAUSE_WDT  = 3'd3,
        CAUSE_PIN  = 3'd4,
        CAUSE_DBG  = 3'd5
    } cause_e;

    // True for causes that take the fixed supply timeout.
    function automatic logic is_supply(input logic [2:0] c);
        return (c == CAUSE_POR) || (c == CAUSE_BOR);
    endfunction

endpackage

// File: rtl/rst_src_merge.sv
// Merges the reset requests into one flag and a priority-encoded cause.
// Assumes: pin level is already synchronised; a low pin is a request.
module rst_src_merge
    import rst_seq_pkg::*;
(
    input  logic       por_i,
    input  logic       bor_i,
    input  logic       wdt_i,
    input  logic       pin_level_i,
    input  logic       dbg_i,
    output logic       any_o,
    output logic [2:0] cause_o
);

    // Any request present this cycle.
    assign any_o = por_i | bor_i | wdt_i | ~pin_level_i | dbg_i;

    // Fixed priority: supply first, then watchdog, pin, debugger.
    always_comb begin
        if (por_i)             cause_o = CAUSE_POR;
        else if (bor_i)        cause_o = CAUSE_BOR;
        else if (wdt_i)        cause_o = CAUSE_WDT;
        else if (!pin_level_i) cause_o = CAUSE_PIN;
        else if (dbg_i)        cause_o = CAUSE_DBG;
        else                   cause_o = CAUSE_NONE;
    end

endmodule

// File: rtl/rst_limit_sel.sv
// Picks the release count from the latched cause and the fuse code.
// Assumes: FUSE_BASE << 7 and SUPPLY_TICKS both fit in CNT_W bits.
module rst_limit_sel
    import rst_seq_pkg::*;
#(
    parameter int CNT_W        = 11,
    parameter int SUPPLY_TICKS = 1025,
    parameter int FUSE_BASE    = 4,
    parameter int FUSE_W       = 3
) (
    input  logic [2:0]        cause_i,
    input  logic [FUSE_W-1:0] fuse_i,
    output logic [CNT_W-1:0]  limit_o
);

    localparam int N_CODES = 1 << FUSE_W;

    logic [CNT_W-1:0] fuse_lut [N_CODES];

    // Fuse table computed as a power-of-two ladder.
    for (genvar k = 0; k < N_CODES; k++) begin : g_lut
        assign fuse_lut[k] = CNT_W'(FUSE_BASE << k);
    end

    // Supply causes use the fixed count, others the fuse entry.
    always_comb begin
        if (is_supply(cause_i)) limit_o = CNT_W'(SUPPLY_TICKS);
        else                    limit_o = fuse_lut[fuse_i];
    end

endmodule

// File: rtl/rst_hold_ctr.sv
// Hold flag plus startup counter. The flag is set by any request and cleared
// after limit_i consecutive request-free edges.
// Assumes: limit_i >= 1 and stable while counting.
module rst_hold_ctr #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             hold_o
);

    logic [CNT_W-1:0] cnt_q;
    logic             hold_q;

    // Set on request, count while quiet, clear at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || req_i) begin
            hold_q <= 1'b1;
            cnt_q  <= '0;
        end else if (hold_q) begin
            if (cnt_q == limit_i - CNT_W'(1)) begin
                hold_q <= 1'b0;
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    assign hold_o = hold_q;

endmodule

// File: rtl/reset_release_seq.sv
// Top of the reset sequencer: request merge, cause register, timeout select
// and hold counter. Runs entirely on the slow RC clock.
// Assumes: rst_n models the initial power-up state and is synchronous.
module reset_release_seq
    import rst_seq_pkg::*;
#(
    parameter int          CNT_W        = 11,
    parameter int          SUPPLY_TICKS = 1025,
    parameter int          FUSE_BASE    = 4,
    parameter int          FUSE_W       = 3,
    parameter int          VEC_W        = 16,
    parameter logic [15:0] RESET_VEC    = 16'hFFF0
) (
    input  logic              clk_slow_i,
    input  logic              rst_n,
    input  logic              por_i,
    input  logic              bor_i,
    input  logic              wdt_ovf_i,
    input  logic              pin_level_i,
    input  logic              dbg_rst_i,
    input  logic [FUSE_W-1:0] fuse_dly_i,
    output logic              core_rst_o,
    output logic [VEC_W-1:0]  rst_vec_o,
    output logic [2:0]        cause_o
);

    logic             req_any;
    logic [2:0]       req_cause;
    logic [2:0]       cause_q;
    logic [CNT_W-1:0] limit;

    rst_src_merge u_merge (
        .por_i       (por_i),
        .bor_i       (bor_i),
        .wdt_i       (wdt_ovf_i),
        .pin_level_i (pin_level_i),
        .dbg_i       (dbg_rst_i),
        .any_o       (req_any),
        .cause_o     (req_cause)
    );

    // Cause register: power-up after init, then latest request.
    always_ff @(posedge clk_slow_i) begin
        if (!rst_n)       cause_q <= CAUSE_POR;
        else if (req_any) cause_q <= req_cause;
    end

    rst_limit_sel #(
        .CNT_W        (CNT_W),
        .SUPPLY_TICKS (SUPPLY_TICKS),
        .FUSE_BASE    (FUSE_BASE),
        .FUSE_W       (FUSE_W)
    ) u_limit (
        .cause_i (cause_q),
        .fuse_i  (fuse_dly_i),
        .limit_o (limit)
    );

    rst_hold_ctr #(
        .CNT_W (CNT_W)
    ) u_hold (
        .clk     (clk_slow_i),
        .rst_n   (rst_n),
        .req_i   (req_any),
        .limit_i (limit),
        .hold_o  (core_rst_o)
    );

    assign rst_vec_o = VEC_W'(RESET_VEC);
    assign cause_o   = cause_q;

endmodule

// File: rtl/rst_seq_chk.sv
// Property checker for reset_release_seq, attached by bind below.
// Assumes: same parameters as the bound instance.
module rst_seq_chk
    import rst_seq_pkg::*;
#(
    parameter int CNT_W        = 11,
    parameter int SUPPLY_TICKS = 1025,
    parameter int FUSE_BASE    = 4,
    parameter int FUSE_W       = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              por_i,
    input logic              bor_i,
    input logic              wdt_ovf_i,
    input logic              pin_level_i,
    input logic              dbg_rst_i,
    input logic [FUSE_W-1:0] fuse_dly_i,
    input logic              core_rst_o,
    input logic [2:0]        cause_o
);

    logic            req;
    logic [CNT_W:0]  quiet_q;

    assign req = por_i | bor_i | wdt_ovf_i | ~pin_level_i | dbg_rst_i;

    // Counts request-free edges seen while the reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n || req)   quiet_q <= '0;
        else if (core_rst_o) quiet_q <= quiet_q + 1'b1;
    end

    // R2
    src_forces_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> core_rst_o);

    // R4
    supply_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(core_rst_o) && is_supply(cause_o)) |->
            (quiet_q == (CNT_W+1)'(SUPPLY_TICKS)));

    // R5
    fuse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(core_rst_o) && !is_supply(cause_o)) |->
            (quiet_q == (CNT_W+1)'(FUSE_BASE << fuse_dly_i)));

    // R7
    cause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> $stable(cause_o));

endmodule

bind reset_release_seq rst_seq_chk #(
    .CNT_W        (CNT_W),
    .SUPPLY_TICKS (SUPPLY_TICKS),
    .FUSE_BASE    (FUSE_BASE),
    .FUSE_W       (FUSE_W)
) u_chk (
    .clk         (clk_slow_i),
    .rst_n       (rst_n),
    .por_i       (por_i),
    .bor_i       (bor_i),
    .wdt_ovf_i   (wdt_ovf_i),
    .pin_level_i (pin_level_i),
    .dbg_rst_i   (dbg_rst_i),
    .fuse_dly_i  (fuse_dly_i),
    .core_rst_o  (core_rst_o),
    .cause_o     (cause_o)
);

// File: tb/tb_reset_release_seq.sv
// Scoreboard bench: driver tasks queue expected values with the cycle they
// are due; a negedge monitor pops and compares them.
module tb_reset_release_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        por = 1'b0, bor = 1'b0, wdt = 1'b0, dbg = 1'b0;
    logic        pin = 1'b1;
    logic [2:0]  fuse = 3'd0;
    logic        core_rst;
    logic [15:0] vec;
    logic [2:0]  cause;

    int unsigned cyc = 0;
    int          n_checks = 0;
    int          n_errs = 0;
    logic        done = 1'b0;

    typedef struct {
        int unsigned due;
        int          req;
        logic        rst;
        logic [2:0]  cause;
    } exp_t;

    exp_t sbq[$];

    reset_release_seq dut (
        .clk_slow_i  (clk),
        .rst_n       (rst_n),
        .por_i       (por),
        .bor_i       (bor),
        .wdt_ovf_i   (wdt),
        .pin_level_i (pin),
        .dbg_rst_i   (dbg),
        .fuse_dly_i  (fuse),
        .core_rst_o  (core_rst),
        .rst_vec_o   (vec),
        .cause_o     (cause)
    );

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compare every item whose due cycle has come.
    always @(negedge clk) begin
        exp_t e;
        while (sbq.size() > 0 && sbq[0].due == cyc) begin
            e = sbq.pop_front();
            n_checks++;
            if (core_rst !== e.rst || cause !== e.cause) begin
                n_errs++;
                $display("FAIL R%0d cyc=%0d rst=%b cause=%0d expected rst=%b cause=%0d",
                         e.req, cyc, core_rst, cause, e.rst, e.cause);
            end
        end
    end

    task automatic push(input int unsigned due, input int req,
                        input logic rst, input logic [2:0] c);
        exp_t e;
        e.due = due; e.req = req; e.rst = rst; e.cause = c;
        sbq.push_back(e);
    endtask

    // mask bits: 0 power-up, 1 brown-out, 2 watchdog, 3 pin, 4 debugger.
    task automatic set_req(input logic [4:0] m);
        por = m[0]; bor = m[1]; wdt = m[2]; pin = ~m[3]; dbg = m[4];
    endtask

    // Assert requests for hold cycles, release, expect release after limit.
    task automatic run_case(input int req, input logic [4:0] m, input int hold,
                            input logic [2:0] f, input int limit,
                            input logic [2:0] c);
        int unsigned c0;
        fuse = f;
        set_req(m);
        push(cyc + 1, 2, 1'b1, c);                       // R2
        push(cyc + hold, m[3] ? 3 : 2, 1'b1, c);         // R3 when pin held
        repeat (hold) @(negedge clk);
        set_req(5'b0);
        c0 = cyc;
        push(c0 + limit - 1, req, 1'b1, c);
        push(c0 + limit, req, 1'b0, c);
        push(c0 + limit + 2, 7, 1'b0, c);                // R7 retention
        repeat (limit + 3) @(negedge clk);
    endtask

    initial begin
        int unsigned c1;
        @(negedge clk);
        push(cyc + 1, 1, 1'b1, 3'd1);                    // R1 reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R4: power-up release from initial state
        push(cyc + 1024, 4, 1'b1, 3'd1);
        push(cyc + 1025, 4, 1'b0, 3'd1);
        repeat (1028) @(negedge clk);

        // R4 brown-out with debugger together: R7 priority gives brown-out
        run_case(4, 5'b10010, 2, 3'd0, 1025, 3'd2);
        // R5 watchdog, fuse 0 -> 4
        run_case(5, 5'b00100, 1, 3'd0, 4, 3'd3);
        // R5 and R3 pin held longer than every timeout, fuse 3 -> 32
        run_case(5, 5'b01000, 2000, 3'd3, 32, 3'd4);
        // R5 debugger, fuse 7 -> 512
        run_case(5, 5'b10000, 3, 3'd7, 512, 3'd5);
        // R7 priority: power-up and watchdog together -> power-up, long count
        run_case(7, 5'b00101, 2, 3'd2, 1025, 3'd1);

        // R6 restart: watchdog with fuse 2 (16), debugger at quiet edge 6
        fuse = 3'd2;
        set_req(5'b00100);
        repeat (3) @(negedge clk);
        set_req(5'b0);
        push(cyc + 5, 6, 1'b1, 3'd3);
        repeat (6) @(negedge clk);
        set_req(5'b10000);
        push(cyc + 1, 6, 1'b1, 3'd5);
        @(negedge clk);
        set_req(5'b0);
        c1 = cyc;
        push(c1 + 15, 6, 1'b1, 3'd5);
        push(c1 + 16, 6, 1'b0, 3'd5);
        repeat (19) @(negedge clk);

        // R8 reset vector is the fixed word address
        n_checks++;
        if (vec !== 16'hFFF0) begin
            n_errs++;
            $display("FAIL R8 rst_vec=%h expected fff0", vec);
        end

        if (sbq.size() != 0) begin
            n_errs++;
            $display("FAIL scoreboard left %0d items unchecked", sbq.size());
        end
        done = 1'b1;
    end

    // Watchdog and summary.
    initial begin
        fork
            wait (done);
            begin
                repeat (200000) @(posedge clk);
                n_errs++;
                $display("FAIL watchdog expired at cyc=%0d", cyc);
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

endmodule